// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

The block counts down from a programmable start value and marks each underflow. Four 32-bit registers sit behind a simple synchronous read/write port. Software programs a start value, turns the counter on and then either polls a sticky underflow flag or takes a one-cycle interrupt request. Each decrement is driven either by every core clock or by an external reference strobe, and a control bit picks which one.

The sequencing lives in a two-state machine. `ST_OFF` means the counter is stopped, `ST_RUN` means it counts. There are four named transitions:

- `START` (`ST_OFF`→`ST_RUN`): a control write with the enable bit set. It loads the start value.
- `STOP` (`ST_RUN`→`ST_OFF`): a control write with the enable bit clear.
- `HALT` (`ST_RUN`→`ST_OFF`): an underflow while the start value is zero.
- `WRAP` (`ST_RUN`→`ST_RUN`): an underflow with a non-zero start value. It reloads the counter.

Two other events also reload the counter while the state stays `ST_RUN`: a write to the current-value register, and a change of the clock-source bit. The enable bit read back from the control register is simply the state.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, start-value and current-value registers read 0, the interrupt request is low, and the timer is stopped.
- R2: The control register sits at offset 0x0. A write there changes only bits [2:0]: bit 0 is enable, bit 1 is interrupt enable, bit 2 is the clock source. A read returns those three bits and the sticky underflow flag at bit 16. Writing the flag bit has no effect on it.
- R3: A read of the control register clears the underflow flag, unless an underflow happens in that same cycle, in which case the flag stays set.
- R4: When enable goes from 0 to 1, the counter loads the start value (offset 0x4). After that, each tick lowers it by one. A read at offset 0x8 returns the counter.
- R5: With the clock-source bit at 1, every core clock is a tick. With it at 0, a tick happens only in cycles where `ref_tick` is high.
- R6: A tick taken while the counter is 0 is an underflow. It sets the flag and reloads the start value, so the period is start value + 1 ticks.
- R7: An underflow with interrupt enable at 1 raises `irq` for exactly one cycle, in the cycle after the underflow edge. With interrupt enable at 0 it raises nothing.
- R8: An underflow with a start value of 0 clears the enable bit and stops the counter.
- R9: A write of any data to offset 0x8 clears the flag. If the timer is running, the write also reloads the counter. No tick is taken in the cycle of a control or current-value write.
- R10: The current-value read returns 0 whenever the timer is stopped.
- R11: Offset 0xC reads as the constant 10000 and ignores writes. Any other offset, including one that is not word-aligned, reads 0 and ignores writes.
- R12: Changing the clock-source bit while the timer stays enabled reloads the counter.
- R13: The start-value register holds CNT_W bits (24 by default). Upper data bits are dropped on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | External reference strobe, counted when the clock-source bit is 0 |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read, 0 when not reading |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
The counter runs under three tick patterns:
- Every core clock. This fixes the exact period.
- A reference strobe high one cycle in three. This shows that decrements follow the strobe and not the clock.
- A strobe held low. This shows the counter freezes.

Control reads are placed on every other cycle, so some of them land on underflow edges. This separates a flag that is cleared by the read from a flag that is set and kept.

Two start values are used:
- A start value of zero separates the one-shot `HALT` path from the `WRAP` path.
- A start value with bits above CNT_W separates truncating registers from full-width ones.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int unsigned DATA_W = 32;

    // Control register bit positions (software decodes these)
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_TIE  = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    // Word indices of the registers (byte offset / 4)
    localparam logic [1:0] WI_CTRL   = 2'd0;
    localparam logic [1:0] WI_RELOAD = 2'd1;
    localparam logic [1:0] WI_CUR    = 2'd2;
    localparam logic [1:0] WI_CAL    = 2'd3;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tt_state_e;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_RELOAD,
        RS_CUR,
        RS_CAL
    } tt_rsel_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_reload;
        logic wr_cur;
        logic rd_ctrl;
    } tt_acc_t;

endpackage

// File: rtl/tt_decode.sv
module tt_decode
    import tt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output tt_acc_t           acc,
    output tt_rsel_e          rsel
);

    localparam int unsigned HI_W = ADDR_W - 4;

    logic       in_map;
    logic [1:0] widx;
    logic       do_wr;
    logic       do_rd;

    assign widx   = bus_addr[3:2];
    assign in_map = (bus_addr[ADDR_W-1:4] == {HI_W{1'b0}}) &&
                    (bus_addr[1:0] == 2'b00);
    assign do_wr  = bus_en && bus_we && in_map;
    assign do_rd  = bus_en && !bus_we && in_map;

    always_comb begin
        acc           = '0;
        acc.wr_ctrl   = do_wr && (widx == WI_CTRL);
        acc.wr_reload = do_wr && (widx == WI_RELOAD);
        acc.wr_cur    = do_wr && (widx == WI_CUR);
        acc.rd_ctrl   = do_rd && (widx == WI_CTRL);
    end

    always_comb begin
        rsel = RS_NONE;
        if (do_rd) begin
            unique case (widx)
                WI_CTRL:   rsel = RS_CTRL;
                WI_RELOAD: rsel = RS_RELOAD;
                WI_CUR:    rsel = RS_CUR;
                WI_CAL:    rsel = RS_CAL;
            endcase
        end
    end

endmodule

// File: rtl/tt_reload_reg.sv
module tt_reload_reg #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end
    end

endmodule

// File: rtl/tt_fsm.sv
module tt_fsm
    import tt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tt_acc_t          acc,
    input  logic [2:0]       ctrl_wdata,
    input  logic [CNT_W-1:0] reload,
    input  logic             ref_tick,
    output logic             run_en,
    output logic             tie,
    output logic             src,
    output logic             flag,
    output logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    tt_state_e        state, nxt_state;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_tie, nxt_src, nxt_flag;
    logic             load, expire;

    // Tick qualifier: core clock or external strobe
    assign step = src ? 1'b1 : ref_tick;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt_state;
        end
    end

    // Next state and datapath decisions
    always_comb begin
        nxt_state = state;
        load      = 1'b0;
        expire    = 1'b0;
        nxt_cnt   = cnt;
        unique case (state)
            ST_OFF: begin
                if (acc.wr_ctrl && ctrl_wdata[BIT_EN]) begin
                    nxt_state = ST_RUN;            // START
                    load      = 1'b1;
                end
            end
            ST_RUN: begin
                if (acc.wr_ctrl) begin
                    if (!ctrl_wdata[BIT_EN]) begin
                        nxt_state = ST_OFF;        // STOP
                    end else if (ctrl_wdata[BIT_SRC] != src) begin
                        load = 1'b1;               // source change reload
                    end
                end else if (acc.wr_cur) begin
                    load = 1'b1;
                end else if (step) begin
                    if (cnt == '0) begin
                        expire = 1'b1;
                        if (reload == '0) begin
                            nxt_state = ST_OFF;    // HALT
                        end else begin
                            load = 1'b1;           // WRAP
                        end
                    end else begin
                        nxt_cnt = cnt - 1'b1;
                    end
                end
            end
        endcase
        if (load) begin
            nxt_cnt = reload;
        end
    end

    always_comb begin
        nxt_tie = acc.wr_ctrl ? ctrl_wdata[BIT_TIE] : tie;
        nxt_src = acc.wr_ctrl ? ctrl_wdata[BIT_SRC] : src;
        if (expire) begin
            nxt_flag = 1'b1;
        end else if (acc.rd_ctrl || acc.wr_cur) begin
            nxt_flag = 1'b0;
        end else begin
            nxt_flag = flag;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tie  <= 1'b0;
            src  <= 1'b0;
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            cnt  <= nxt_cnt;
            tie  <= nxt_tie;
            src  <= nxt_src;
            flag <= nxt_flag;
            irq  <= expire && tie;
        end
    end

    assign run_en = (state == ST_RUN);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam logic [DATA_W-1:0] CAL_WORD = DATA_W'(CAL_VALUE);

    tt_acc_t          acc;
    tt_rsel_e         rsel;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_val;
    logic             run_en, tie, src, cnt_flag, step;
    logic [31:0]      ctrl_word;
    logic [31:0]      reload_word;
    logic [31:0]      cur_word;

    tt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc      (acc),
        .rsel     (rsel)
    );

    tt_reload_reg #(.CNT_W(CNT_W)) u_rld (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (acc.wr_reload),
        .wdata (bus_wdata[CNT_W-1:0]),
        .value (reload_val)
    );

    tt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .ctrl_wdata (bus_wdata[2:0]),
        .reload     (reload_val),
        .ref_tick   (ref_tick),
        .run_en     (run_en),
        .tie        (tie),
        .src        (src),
        .flag       (cnt_flag),
        .step       (step),
        .cnt        (cnt_val),
        .irq        (irq)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = run_en;
        ctrl_word[BIT_TIE]  = tie;
        ctrl_word[BIT_SRC]  = src;
        ctrl_word[BIT_FLAG] = cnt_flag;
    end

    generate
        if (CNT_W < DATA_W) begin : g_ext
            assign reload_word = {{(DATA_W-CNT_W){1'b0}}, reload_val};
            assign cur_word    = run_en ? {{(DATA_W-CNT_W){1'b0}}, cnt_val} : '0;
        end else begin : g_full
            assign reload_word = reload_val;
            assign cur_word    = run_en ? cnt_val : '0;
        end
    endgenerate

    always_comb begin
        unique case (rsel)
            RS_CTRL:   bus_rdata = ctrl_word;
            RS_RELOAD: bus_rdata = reload_word;
            RS_CUR:    bus_rdata = cur_word;
            RS_CAL:    bus_rdata = CAL_WORD;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CAL_VALUE = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              run_en,
    input logic              cnt_flag,
    input logic              step,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  reload_val
);

    logic rd_cur, rd_cal, wr_ctrl, wr_cur;

    assign rd_cur  = bus_en && !bus_we && (bus_addr == ADDR_W'(8));
    assign rd_cal  = bus_en && !bus_we && (bus_addr == ADDR_W'(12));
    assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(0));
    assign wr_cur  = bus_en && bus_we && (bus_addr == ADDR_W'(8));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_flag);

    assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && !run_en) |-> (bus_rdata == 32'd0));

    assert_cal_const_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cal |-> (bus_rdata == 32'(CAL_VALUE)));

    assert_ctrl_wr_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> $stable(cnt_flag));

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step && cnt_val == '0 && reload_val == '0 && !wr_ctrl && !wr_cur)
        |=> !run_en);

endmodule

bind tick_timer tt_checker #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CAL_VALUE (CAL_VALUE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .run_en     (run_en),
    .cnt_flag   (cnt_flag),
    .step       (step),
    .cnt_val    (cnt_val),
    .reload_val (reload_val)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam int unsigned AW = 8;
    localparam int unsigned CW = 24;
    localparam int unsigned MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    bit          m_en, m_tie, m_src, m_flag, m_irq;
    int unsigned m_reload, m_cnt;

    always #4 clk = ~clk;

    tick_timer #(.ADDR_W(AW), .CNT_W(CW), .CAL_VALUE(10000)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int unsigned exp_read(int unsigned a);
        case (a)
            0:  return (int'(m_flag) << 16) | (int'(m_src) << 2) |
                       (int'(m_tie) << 1) | int'(m_en);
            4:  return m_reload;
            8:  return m_en ? m_cnt : 0;
            12: return 10000;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit en, bit we, int unsigned a, int unsigned d, bit rt);
        bit wctrl = en && we && a == 0;
        bit wrld  = en && we && a == 4;
        bit wcur  = en && we && a == 8;
        bit rctrl = en && !we && a == 0;
        bit tick  = m_src || rt;
        bit exp_f = 0;
        bit n_en  = m_en;
        int unsigned n_cnt = m_cnt;
        if (wctrl) begin
            n_en = d[0];
            if (!m_en && d[0]) n_cnt = m_reload;
            else if (m_en && d[0] && (d[2] != m_src)) n_cnt = m_reload;
        end else if (wcur) begin
            if (m_en) n_cnt = m_reload;
        end else if (m_en && tick) begin
            if (m_cnt == 0) begin
                exp_f = 1;
                if (m_reload == 0) n_en = 0;
                else n_cnt = m_reload;
            end else begin
                n_cnt = m_cnt - 1;
            end
        end
        m_irq = exp_f && m_tie;
        if (exp_f) m_flag = 1;
        else if (rctrl || wcur) m_flag = 0;
        if (wctrl) begin
            m_tie = d[1];
            m_src = d[2];
        end
        if (wrld) m_reload = d & MASK;
        m_en  = n_en;
        m_cnt = n_cnt;
    endtask

    // One bus cycle: drive, compare, advance the model
    task automatic cyc(bit en, bit we, int unsigned a, int unsigned d, bit rt, string tag);
        @(negedge clk);
        bus_en    = en;
        bus_we    = we;
        bus_addr  = AW'(a);
        bus_wdata = d;
        ref_tick  = rt;
        #1;
        check("R7 irq", 32'(irq), 32'(m_irq));
        if (en && !we) check(tag, bus_rdata, exp_read(a));
        else check(tag, bus_rdata, 0);
        @(posedge clk);
        model_step(en, we, a, d, rt);
    endtask

    task automatic wr(int unsigned a, int unsigned d, string tag);
        cyc(1, 1, a, d, 0, tag);
    endtask

    task automatic rd(int unsigned a, string tag);
        cyc(1, 0, a, 0, 0, tag);
    endtask

    // Run with alternating control / current-value reads; strobe every p cycles
    task automatic run(int n, int p, string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, (i % 2 == 0) ? 8 : 0, 0, (p > 0) && (i % p == 0), tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_en = 0; m_tie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        m_reload = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, "R1 ctrl");
        rd(4, "R1 reload");
        rd(8, "R1 cur");

        // R13 width of start value
        wr(4, 32'hFFFF_FFFF, "R13 write");
        rd(4, "R13 readback");

        // R4/R6 periodic counting on core clock, no interrupt
        wr(4, 5, "R4 reload");
        wr(0, 32'h5, "R4 enable");
        run(20, 0, "R6 period");

        // R7 interrupt enabled, enable unchanged
        wr(0, 32'h7, "R7 tie on");
        run(16, 0, "R7 run");

        // R2 write with flag/high bits set; source change reloads (R12)
        wr(0, 32'hFFFF_0003, "R2 ctrl write");
        rd(0, "R2 ctrl read");
        rd(8, "R12 reload on source change");
        run(30, 3, "R5 ref strobe");
        run(6, 0, "R5 no strobe");

        // R9 current-value write
        run(40, 1, "R3 flag set");
        wr(8, 32'hDEAD_BEEF, "R9 cur write");
        rd(0, "R9 flag cleared");
        rd(8, "R9 reloaded");

        // R11 calibration and undefined offsets
        wr(12, 32'h1234, "R11 cal write");
        wr(16, 32'h55, "R11 undef write");
        rd(12, "R11 cal read");
        rd(16, "R11 undef read");
        rd(3, "R11 misaligned read");
        rd(4, "R11 reload untouched");

        // R10 disabled reads zero
        wr(0, 32'h2, "R10 disable");
        rd(8, "R10 cur off");
        run(4, 0, "R10 run off");

        // R8 zero start value halts
        wr(4, 0, "R8 reload zero");
        wr(0, 32'h7, "R8 enable");
        run(6, 1, "R8 halted");

        // R12 source change while running
        wr(4, 3, "R12 reload");
        wr(0, 32'h5, "R12 enable");
        run(5, 0, "R12 run");
        wr(0, 32'h1, "R12 source flip");
        rd(8, "R12 cur after flip");
        run(8, 2, "R12 ref run");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule